// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Output Registers

This block is one bank of general-purpose I/O pins. It sits behind a simple word-addressed register bus and has one bit per pin in each register. Software picks each pin's direction in a direction register. It changes the pin output values only through two strobe registers. Writing a mask to one of them forces the masked latch bits high. Writing a mask to the other forces them low. Because of this, two agents can update different pins without a read-modify-write race.

An input register always shows the level seen at the pads. This holds for pins that are inputs and for pins that the bank drives itself. The pad levels reach that register through a two-flop synchronizer in the bank clock domain. As a result, a read made just after an output change still returns the old level for a short window.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset the direction register reads all ones, so every pin is an input. The output latch reads zero, `pad_oe` is zero and `pad_out` is zero.
- R2: A write to address 0 (direction) stores the word. A direction bit of 1 makes that pin an input and 0 makes it an output. From the next cycle `pad_oe` equals the bitwise inverse of the stored word, and a read of address 0 returns the word.
- R3: A write to address 2 (set strobe) forces every latch bit whose write bit is 1 to one. Latch bits whose write bit is 0 keep their value.
- R4: A write to address 3 (clear strobe) forces every latch bit whose write bit is 1 to zero. Latch bits whose write bit is 0 keep their value.
- R5: `pad_out` always equals the output latch, whatever the direction bits are.
- R6: A read of address 4 (input) returns the pad level of every pin, output pins included. A change on `pad_in` just before clock edge k becomes visible after edge k+1. After edge k alone, the read still returns the old level.
- R7: Reads of address 1 (latch readback), address 2 and address 3 all return the current output latch.
- R8: Writes to address 1, address 4 and addresses 5 to 7 change neither the latch nor the direction register. Reads of addresses 5 to 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock; all state and the synchronizer run on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register being accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | PINS (32) | Write data, one bit per pin |
| bus_rdata | output | PINS (32) | Read data for `bus_addr`, combinational |
| pad_in | input | PINS (32) | Raw, asynchronous pad levels |
| pad_out | output | PINS (32) | Value to drive on each pad |
| pad_oe | output | PINS (32) | Drive enable per pad, high for output pins |

## Verification
Register writes take effect at the clock edge that samples the strobe. The direction, latch, `pad_out` and `pad_oe` results are therefore due one edge after the write. The bench drives each write in the low phase and checks the result in the next low phase. Input reads lag the pad by two edges. The bench samples the input register after one edge, where it expects the old level, and after two edges, where it expects the new one. It does this for driven pins through a loopback of `pad_out` onto `pad_in`, and for pins that are inputs through an external value. Combinational reads are settled in the low phase, well away from any rising edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_DIR = 3'd0,
    REG_OUT = 3'd1,
    REG_SET = 3'd2,
    REG_CLR = 3'd3,
    REG_IN  = 3'd4
  } gpio_reg_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_raw,
  output logic [W-1:0] pad_synced
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [1:0]   age_q;
  logic         sync_primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_raw;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assign sync_primed = (age_q == 2'd2);
  assign pad_synced  = sync_q;

  // R6
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_primed |-> (pad_synced == $past(pad_raw, 2)));
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      lat_q
);
  function automatic logic [W-1:0] set_mask(input logic [W-1:0] cur, input logic [W-1:0] m);
    return cur | m;
  endfunction

  function automatic logic [W-1:0] clr_mask(input logic [W-1:0] cur, input logic [W-1:0] m);
    return cur & ~m;
  endfunction

  logic dir_hit, set_hit, clr_hit, nop_hit;

  assign dir_hit = wr_en && (wr_addr == REG_DIR);
  assign set_hit = wr_en && (wr_addr == REG_SET);
  assign clr_hit = wr_en && (wr_addr == REG_CLR);
  assign nop_hit = wr_en && !dir_hit && !set_hit && !clr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '1;
    else if (dir_hit) dir_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (set_hit) lat_q <= set_mask(lat_q, wr_data);
    else if (clr_hit) lat_q <= clr_mask(lat_q, wr_data);
  end

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((lat_q & $past(wr_data)) == $past(wr_data)));
  // R3
  set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((lat_q & ~$past(wr_data)) == ($past(lat_q) & ~$past(wr_data))));
  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((lat_q & $past(wr_data)) == '0));
  // R4
  clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((lat_q | $past(wr_data)) == ($past(lat_q) | $past(wr_data))));
  // R8
  nop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nop_hit |=> ($stable(lat_q) && $stable(dir_q)));
  // R2
  dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_hit |=> (dir_q == $past(wr_data)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      lat_q,
  input  logic [W-1:0]      pad_synced,
  output logic [W-1:0]      rd_data
);
  always_comb begin
    unique case (rd_addr)
      REG_DIR:                   rd_data = dir_q;
      REG_OUT, REG_SET, REG_CLR: rd_data = lat_q;
      REG_IN:                    rd_data = pad_synced;
      default:                   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic [PINS-1:0] dir_q, lat_q, pad_synced;

  gpio_ctrl_regs #(.W(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .dir_q(dir_q), .lat_q(lat_q)
  );

  gpio_pad_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_raw(pad_in), .pad_synced(pad_synced)
  );

  gpio_read_mux #(.W(PINS)) u_rmux (
    .rd_addr(bus_addr), .dir_q(dir_q), .lat_q(lat_q),
    .pad_synced(pad_synced), .rd_data(bus_rdata)
  );

  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;

  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_DIR) |=> (pad_oe == ~$past(bus_wdata)));
  // R7
  strobe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_SET || bus_addr == REG_CLR) |-> (bus_rdata == pad_out));
  // R8
  hole_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > REG_IN) |-> (bus_rdata == '0));
endmodule

// File: tb/test_gpio_setclr_bank.sv
`timescale 1ns/1ps
module test_gpio_setclr_bank;
  localparam int P = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [P-1:0] bus_wdata = '0;
  logic [P-1:0] bus_rdata, pad_in, pad_out, pad_oe;
  logic [P-1:0] ext = '0;
  logic loop_en = 1'b0;
  int errors = 0, checks = 0;
  logic [P-1:0] m_dir, m_lat;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  assign pad_in = loop_en ? ((pad_out & pad_oe) | (ext & ~pad_oe)) : ext;

  gpio_setclr_bank #(.PINS(P)) i_gpio_setclr_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic chk(input string req, input logic [P-1:0] act, input logic [P-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [P-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      3'd0: m_dir = d;
      3'd2: m_lat = m_lat | d;
      3'd3: m_lat = m_lat & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [P-1:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [P-1:0] v;
    rd(3'd1, v); chk(req, v, m_lat);
    rd(3'd0, v); chk(req, v, m_dir);
    chk("R5", pad_out, m_lat);
    chk("R2", pad_oe, ~m_dir);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [P-1:0] v, old, a, b, c;
    m_dir = '1; m_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    chk("R1", pad_oe, '0);
    chk("R1", pad_out, '0);

    // sweep of patterns: R3 R4 R2 R7 R8
    for (int i = 0; i < 48; i++) begin
      seed = next_rand(seed); a = seed;
      seed = next_rand(seed); b = seed;
      seed = next_rand(seed); c = seed;
      wr(3'd2, a); check_regs("R3");
      wr(3'd3, b); check_regs("R4");
      rd(3'd2, v); chk("R7", v, m_lat);
      rd(3'd3, v); chk("R7", v, m_lat);
      wr(3'd0, c); check_regs("R2");
      wr(3'd1, ~m_lat); check_regs("R8");
      wr(3'd4, ~m_lat); check_regs("R8");
      wr(3'(5 + (i % 3)), a ^ b); check_regs("R8");
      rd(3'(5 + (i % 3)), v); chk("R8", v, '0);
    end

    // walking single bits: R3 R4 boundaries
    wr(3'd3, '1); check_regs("R4");
    for (int k = 0; k < P; k++) begin
      wr(3'd2, P'(1) << k); check_regs("R3");
      chk("R3", pad_out, P'(1) << k);
      wr(3'd3, P'(1) << k); check_regs("R4");
      chk("R4", pad_out, '0);
    end
    wr(3'd2, '1); check_regs("R3");
    wr(3'd3, 32'h0000_0000); check_regs("R4");

    // R6 latency through loopback on driven pins
    loop_en = 1'b1;
    wr(3'd0, '0);
    wr(3'd3, '1);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R6", v, '0);
    a = 32'hA5C3_0F81;
    wr(3'd2, a);
    rd(3'd4, v); chk("R6", v, '0);
    @(negedge clk); rd(3'd4, v); chk("R6", v, '0);
    @(negedge clk); rd(3'd4, v); chk("R6", v, a);
    wr(3'd3, 32'hFFFF_0000);
    rd(3'd4, v); chk("R6", v, a);
    @(negedge clk); rd(3'd4, v); chk("R6", v, a);
    @(negedge clk); rd(3'd4, v); chk("R6", v, a & 32'h0000_FFFF);

    // R6 mixed direction: upper half inputs from ext, lower half driven
    wr(3'd0, 32'hFFFF_0000);
    ext = 32'h3C5A_9999;
    repeat (3) @(negedge clk);
    old = (m_lat & 32'h0000_FFFF) | (ext & 32'hFFFF_0000);
    rd(3'd4, v); chk("R6", v, old);
    for (int j = 0; j < 8; j++) begin
      seed = next_rand(seed);
      ext = seed;
      @(negedge clk); rd(3'd4, v); chk("R6", v, old);
      @(negedge clk);
      old = (m_lat & 32'h0000_FFFF) | (ext & 32'hFFFF_0000);
      rd(3'd4, v); chk("R6", v, old);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule